// File: doc/BRIEF.md
# Last Branch and Interrupt Recorder

This block keeps a debug record of control-flow changes seen at retirement. On each cycle it may receive a taken-branch strobe with source and target addresses, an interrupt strobe with the interrupted and handler addresses, or both at once. A 16-bit debug-control register decides two things. Its record-enable bit decides whether these strobes are captured. Its branch-trap bit decides whether a taken branch raises a single-step trap request toward the trap logic.

Software reads and writes the control register, and reads the four 32-bit record registers, through a small register port. Writes take effect at the clock edge. Reads are combinational from the stored values. The trap request comes from a two-state machine. `TRAP_IDLE` moves to `TRAP_FIRE` on a taken branch while the trap bit is set. `TRAP_FIRE` stays in `TRAP_FIRE` if another such branch arrives, and otherwise returns to `TRAP_IDLE`. `TRAP_IDLE` stays in `TRAP_IDLE` when no qualifying branch arrives.

Top module: `branch_irq_recorder`

## Requirements
- R1: After reset, the control register, all four records and `trap_req` read as zero.
- R2: When control bit 0 is 1 and `br_valid` is 1, the branch-source record (address 1) takes `br_from` and the branch-target record (address 2) takes `br_to` at that clock edge.
- R3: When control bit 0 is 1 and `irq_valid` is 1, the interrupt-source record (address 3) takes `irq_from` and the interrupt-target record (address 4) takes `irq_to` at that clock edge.
- R4: When control bit 0 is 0, all four records keep their values whatever the strobes do.
- R5: A branch strobe changes only the branch pair, and an interrupt strobe changes only the interrupt pair.
- R6: When both strobes arrive in the same cycle with recording enabled, both pairs update.
- R7: When control bit 1 is 1 and `br_valid` is 1, `trap_req` is high for exactly the following cycle. It then falls unless another qualifying branch arrives.
- R8: When control bit 1 is 0, `trap_req` stays low. Interrupts never raise it.
- R9: Control bits 13..7 ignore writes and always read 0.
- R10: Control bits 15..14 and 6..0 read back the value last written (address 0, `reg_wdata`).
- R11: Register addresses 5 to 7 read as zero.
- R12: Strobes are judged against the control value held before the edge, so a control write in the same cycle applies only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_valid | input | 1 | Taken-branch retire strobe |
| br_from | input | 32 | Branch source address |
| br_to | input | 32 | Branch target address |
| irq_valid | input | 1 | Interrupt-taken strobe |
| irq_from | input | 32 | Address at which the interrupt occurred |
| irq_to | input | 32 | Address the interrupt transferred to |
| reg_addr | input | 3 | Register select (0 control, 1..4 records) |
| reg_wen | input | 1 | Write strobe for the control register |
| reg_wdata | input | 16 | Control write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| trap_req | output | 1 | Single-step trap request pulse |

## Verification
The assertions assume that both strobes are clean single-cycle qualifiers that are never X after reset. They also assume that address inputs are only meaningful while their strobe is high, so a hold property tracks the records and never the raw address buses. The bench drives each strobe for exactly one cycle, changes inputs only at the falling edge, and sweeps every combination of enable bit, trap bit, branch strobe and interrupt strobe. Between combinations it also writes control patterns that cover every single bit.

// File: rtl/brrec_pkg.sv
package brrec_pkg;
    localparam int ADDR_W  = 32;
    localparam int CTRL_W  = 16;
    localparam int SEL_W   = 3;
    // control bit positions that the logic decodes
    localparam int BIT_REC  = 0;
    localparam int BIT_TRAP = 1;
    // bits 13..7 are reserved
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 16'hC07F;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
    localparam logic [SEL_W-1:0] SEL_BR_F = 3'd1;
    localparam logic [SEL_W-1:0] SEL_BR_T = 3'd2;
    localparam logic [SEL_W-1:0] SEL_IQ_F = 3'd3;
    localparam logic [SEL_W-1:0] SEL_IQ_T = 3'd4;

    typedef enum logic {
        TRAP_IDLE = 1'b0,
        TRAP_FIRE = 1'b1
    } trap_state_t;
endpackage

// File: rtl/brrec_ctrl.sv
module brrec_ctrl #(
    parameter int W = 16,
    parameter logic [W-1:0] WMASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wen,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ctrl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wen)
            ctrl_q <= wdata & WMASK;
    end
endmodule

// File: rtl/brrec_pair.sv
module brrec_pair #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] src_in,
    input  logic [W-1:0] dst_in,
    output logic [W-1:0] src_q,
    output logic [W-1:0] dst_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (capture) begin
            src_q <= src_in;
            dst_q <= dst_in;
        end
    end
endmodule

// File: rtl/brrec_trap.sv
module brrec_trap
    import brrec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic qualify,
    output logic trap_req
);
    trap_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TRAP_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRAP_IDLE: state_d = qualify ? TRAP_FIRE : TRAP_IDLE;
            TRAP_FIRE: state_d = qualify ? TRAP_FIRE : TRAP_IDLE;
            default:   state_d = TRAP_IDLE;
        endcase
    end

    always_comb begin
        trap_req = 1'b0;
        unique case (state_q)
            TRAP_IDLE: trap_req = 1'b0;
            TRAP_FIRE: trap_req = 1'b1;
            default:   trap_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_irq_recorder.sv
module branch_irq_recorder
    import brrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_from,
    input  logic [ADDR_W-1:0] br_to,
    input  logic              irq_valid,
    input  logic [ADDR_W-1:0] irq_from,
    input  logic [ADDR_W-1:0] irq_to,
    input  logic [SEL_W-1:0]  reg_addr,
    input  logic              reg_wen,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              trap_req
);
    localparam int NPAIR = 2;

    logic [CTRL_W-1:0] ctrl_q;
    logic              rec_en;
    logic [NPAIR-1:0]  strobe;
    logic [ADDR_W-1:0] src_in [NPAIR];
    logic [ADDR_W-1:0] dst_in [NPAIR];
    logic [ADDR_W-1:0] src_q  [NPAIR];
    logic [ADDR_W-1:0] dst_q  [NPAIR];

    brrec_ctrl #(.W(CTRL_W), .WMASK(CTRL_WMASK)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wen    (reg_wen && (reg_addr == SEL_CTRL)),
        .wdata  (reg_wdata),
        .ctrl_q (ctrl_q)
    );

    assign rec_en    = ctrl_q[BIT_REC];
    assign strobe    = {irq_valid, br_valid};
    assign src_in[0] = br_from;
    assign dst_in[0] = br_to;
    assign src_in[1] = irq_from;
    assign dst_in[1] = irq_to;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        brrec_pair #(.W(ADDR_W)) u_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (rec_en && strobe[g]),
            .src_in  (src_in[g]),
            .dst_in  (dst_in[g]),
            .src_q   (src_q[g]),
            .dst_q   (dst_q[g])
        );
    end

    brrec_trap u_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .qualify  (br_valid && ctrl_q[BIT_TRAP]),
        .trap_req (trap_req)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            SEL_CTRL: reg_rdata = {{(ADDR_W-CTRL_W){1'b0}}, ctrl_q};
            SEL_BR_F: reg_rdata = src_q[0];
            SEL_BR_T: reg_rdata = dst_q[0];
            SEL_IQ_F: reg_rdata = src_q[1];
            SEL_IQ_T: reg_rdata = dst_q[1];
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/brrec_checker.sv
module brrec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        br_valid,
    input logic [31:0] br_from,
    input logic [31:0] br_to,
    input logic        irq_valid,
    input logic [31:0] irq_from,
    input logic [31:0] irq_to,
    input logic [15:0] ctrl,
    input logic [31:0] bf,
    input logic [31:0] bt,
    input logic [31:0] qf,
    input logic [31:0] qt,
    input logic        trap_req
);
    assert_br_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && br_valid) |=> (bf == $past(br_from) && bt == $past(br_to)));

    assert_irq_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[0] && irq_valid) |=> (qf == $past(irq_from) && qt == $past(irq_to)));

    assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |=> ($stable(bf) && $stable(bt) && $stable(qf) && $stable(qt)));

    assert_br_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> ($stable(bf) && $stable(bt)));

    assert_irq_isolated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |=> ($stable(qf) && $stable(qt)));

    assert_trap_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[1] && br_valid) |=> trap_req);

    assert_no_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl[1] && br_valid) |=> !trap_req);

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[13:7] == 7'd0);
endmodule

bind branch_irq_recorder brrec_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_valid  (br_valid),
    .br_from   (br_from),
    .br_to     (br_to),
    .irq_valid (irq_valid),
    .irq_from  (irq_from),
    .irq_to    (irq_to),
    .ctrl      (ctrl_q),
    .bf        (src_q[0]),
    .bt        (dst_q[0]),
    .qf        (src_q[1]),
    .qt        (dst_q[1]),
    .trap_req  (trap_req)
);

// File: tb/sim_branch_irq_recorder.sv
module sim_branch_irq_recorder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0, irq_valid = 1'b0, reg_wen = 1'b0;
    logic [31:0] br_from = '0, br_to = '0, irq_from = '0, irq_to = '0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        trap_req;

    int checks = 0, errors = 0;
    logic [15:0] m_ctrl = '0;
    logic [31:0] m_bf = '0, m_bt = '0, m_qf = '0, m_qt = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    branch_irq_recorder u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(string req, logic [2:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic check_all(string req);
        rd(req, 3'd0, {16'd0, m_ctrl});
        rd(req, 3'd1, m_bf);
        rd(req, 3'd2, m_bt);
        rd(req, 3'd3, m_qf);
        rd(req, 3'd4, m_qt);
    endtask

    task automatic wr_ctrl(logic [15:0] v);
        @(negedge clk);
        reg_addr = 3'd0; reg_wdata = v; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
        m_ctrl = v & 16'hC07F;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all("R1");
        check("R1 trap", {31'd0, trap_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 R10: single-bit write sweep
        for (int b = 0; b < 16; b++) begin
            wr_ctrl(16'h1 << b);
            rd((b >= 7 && b <= 13) ? "R9" : "R10", 3'd0, {16'd0, (16'h1 << b) & 16'hC07F});
        end
        wr_ctrl(16'hFFFF);
        rd("R9 R10 all ones", 3'd0, 32'h0000_C07F);

        // R11: unmapped addresses
        for (int a = 5; a < 8; a++) rd("R11", 3'(a), 32'd0);

        // R2-R8: sweep enable, trap, branch, interrupt
        for (int c = 0; c < 16; c++) begin
            logic en, tr, b, i;
            en = c[0]; tr = c[1]; b = c[2]; i = c[3];
            wr_ctrl({14'd0, tr, en});
            br_valid = b; irq_valid = i;
            br_from  = 32'h1000_0000 + 32'(c) * 32'h111;
            br_to    = 32'h2000_0000 + 32'(c) * 32'h222;
            irq_from = 32'h3000_0000 + 32'(c) * 32'h333;
            irq_to   = 32'h4000_0000 + 32'(c) * 32'h444;
            @(negedge clk);
            br_valid = 1'b0; irq_valid = 1'b0;
            if (en && b) begin m_bf = br_from; m_bt = br_to; end
            if (en && i) begin m_qf = irq_from; m_qt = irq_to; end
            // R2 R3 R4 R5 R6 via model comparison
            check_all(en ? (b && i ? "R6" : "R2 R3 R5") : "R4");
            check(tr ? "R7 rise" : "R8", {31'd0, trap_req}, {31'd0, tr && b});
            @(negedge clk);
            check("R7 one cycle", {31'd0, trap_req}, 32'd0);
        end

        // R7: back-to-back qualifying branches hold the request
        wr_ctrl(16'h0002);
        br_valid = 1'b1;
        @(negedge clk);
        check("R7 b2b first", {31'd0, trap_req}, 32'd1);
        @(negedge clk);
        br_valid = 1'b0;
        check("R7 b2b second", {31'd0, trap_req}, 32'd1);
        @(negedge clk);
        check("R7 fall", {31'd0, trap_req}, 32'd0);

        // R12: write enabling recording in same cycle as a branch
        wr_ctrl(16'h0000);
        reg_addr = 3'd0; reg_wdata = 16'h0001; reg_wen = 1'b1;
        br_valid = 1'b1; br_from = 32'hDEAD_0001; br_to = 32'hBEEF_0002;
        @(negedge clk);
        reg_wen = 1'b0; br_valid = 1'b0; m_ctrl = 16'h0001;
        check_all("R12");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule